// File: doc/BRIEF.md
# Ordered Run Window Detector

This block watches a byte stream and flags every place where the latest eight accepted symbols form three runs: first one or more `a`, then one or more `b`, then one or more `c`. A symbol is accepted on any clock where the valid strobe is high. When an accepted symbol completes such a window, a one-cycle report pulse follows on the next clock. A 32-bit position value is captured with the pulse and stays until the next report. The position is the 1-based index, counted since reset, of the symbol that closed the window.

The matcher is a one-hot automaton with three tracks of state bits, one for each letter. Each bit stands for a letter seen at a given offset inside a candidate window. All bits advance together, so every candidate start is followed at the same time. A new window can therefore open on any symbol while earlier ones are still in flight. Overlapping and back-to-back matches are all reported, and a mismatch never forces a restart.

Top module: `seqdet_ordered_match`

## Requirements
- R1: On a clock where `valid_i` is high and the accepted symbol completes an eight-symbol window of the form a+b+c+, `report_o` is high during the following cycle. In every other cycle it is low.
- R2: A reported window starts with `a` (8'h61) and ends with `c` (8'h63). For example, `abcccccc` reports on its eighth symbol.
- R3: Inside a window, `a` may be followed only by `a` or `b` (8'h62), `b` only by `b` or `c`, and `c` only by `c`. The boundary case `aaaaaabc`, with `a` in the sixth slot, still reports.
- R4: A candidate window may begin on any accepted symbol, even while others are still in progress. Overlapping windows each report, on consecutive accepted symbols if they are adjacent.
- R5: Seven `a` followed by one `c` never reports. At least one `b` must lie between the last `a` and the first `c`.
- R6: On a clock where `valid_i` is low, the symbol is ignored. No partial match advances or decays, and `report_o` is low in the following cycle.
- R7: `rst_ni` low clears all partial matches, `report_o` and `pos_o` at once. The first symbol accepted after release may open a window.
- R8: `pos_o` is updated only when a report is raised. It then takes the count of accepted symbols since reset, including the one that closed the window, modulo 2^32.
- R9: Any accepted byte other than `a`, `b` or `c` ends every partial match in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Symbol on `sym_i` is accepted this cycle |
| sym_i | input | 8 | Input symbol byte |
| report_o | output | 1 | One-cycle pulse after a qualifying window closes |
| pos_o | output | 32 | Stream index of the symbol that closed the last reported window |

## Verification
The bench builds the block with its default parameters: an eight-symbol window, letter codes 8'h61 to 8'h63 and a 32-bit position counter. With these values the sixth-slot limit of the `a` track and the final `b`-to-`c` step can be reached by short directed strings. Biased random runs over `a`, `b`, `c` and the stray letter `d`, with idle cycles mixed in, give frequent overlapping matches and frequent killed paths. Every report and position value is checked against a sliding-window model.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  typedef struct packed {
    logic is_a;
    logic is_b;
    logic is_c;
  } sym_class_t;
endpackage

// File: rtl/seqdet_classify.sv
module seqdet_classify
  import seqdet_pkg::*;
#(
  parameter int unsigned SYM_W = 8,
  parameter logic [SYM_W-1:0] A_CODE = 8'h61,
  parameter logic [SYM_W-1:0] B_CODE = 8'h62,
  parameter logic [SYM_W-1:0] C_CODE = 8'h63
) (
  input  logic [SYM_W-1:0] sym_i,
  output sym_class_t       class_o
);
  always_comb begin
    class_o.is_a = (sym_i == A_CODE);
    class_o.is_b = (sym_i == B_CODE);
    class_o.is_c = (sym_i == C_CODE);
  end
endmodule

// File: rtl/seqdet_track.sv
// One letter's state bits, indexed by position inside the window.
module seqdet_track #(
  parameter int unsigned LO = 1,
  parameter int unsigned HI = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          hit_i,
  input  logic [HI:LO]  entry_i,
  output logic [HI:LO]  state_o
);
  logic [HI:LO] state_q, state_d;

  always_comb begin
    state_d[LO] = hit_i & entry_i[LO];
  end

  for (genvar p = LO + 1; p <= HI; p++) begin : g_pos
    always_comb state_d[p] = hit_i & (entry_i[p] | state_q[p-1]);

    p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i |=> (!state_q[p] || $past(entry_i[p] | state_q[p-1])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (adv_i) state_q <= state_d;
  end

  assign state_o = state_q;

  p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));

  p_kill_on_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !hit_i) |=> (state_q == '0));
endmodule

// File: rtl/seqdet_report.sv
module seqdet_report #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             hit_i,
  output logic             report_o,
  output logic [CNT_W-1:0] pos_o
);
  logic [CNT_W-1:0] cnt_q, pos_q;
  logic             report_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      pos_q    <= '0;
      report_q <= 1'b0;
    end else begin
      report_q <= adv_i & hit_i;
      if (adv_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (hit_i) pos_q <= cnt_q + 1'b1;
      end
    end
  end

  assign report_o = report_q;
  assign pos_o    = pos_q;

  p_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_pos_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !report_q |-> $stable(pos_q));

  p_report_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> !report_q);
endmodule

// File: rtl/seqdet_ordered_match.sv
// a+b+c+ window detector; WIN_LEN must be at least 4.
module seqdet_ordered_match
  import seqdet_pkg::*;
#(
  parameter int unsigned SYM_W   = 8,
  parameter int unsigned WIN_LEN = 8,
  parameter int unsigned CNT_W   = 32,
  parameter logic [SYM_W-1:0] A_CODE = 8'h61,
  parameter logic [SYM_W-1:0] B_CODE = 8'h62,
  parameter logic [SYM_W-1:0] C_CODE = 8'h63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             report_o,
  output logic [CNT_W-1:0] pos_o
);
  localparam int unsigned A_LO = 1;
  localparam int unsigned A_HI = WIN_LEN - 2;
  localparam int unsigned B_LO = 2;
  localparam int unsigned B_HI = WIN_LEN - 1;
  localparam int unsigned C_LO = 3;
  localparam int unsigned C_HI = WIN_LEN - 1;

  sym_class_t   cls;
  logic [A_HI:A_LO] a_entry, a_state;
  logic [B_HI:B_LO] b_entry, b_state;
  logic [C_HI:C_LO] c_entry, c_state;
  logic             final_hit;

  seqdet_classify #(
    .SYM_W(SYM_W), .A_CODE(A_CODE), .B_CODE(B_CODE), .C_CODE(C_CODE)
  ) u_classify (
    .sym_i  (sym_i),
    .class_o(cls)
  );

  // A window may open on any symbol.
  always_comb begin
    a_entry       = '0;
    a_entry[A_LO] = 1'b1;
  end

  for (genvar p = B_LO; p <= B_HI; p++) begin : g_b_entry
    assign b_entry[p] = a_state[p-1];
  end

  for (genvar p = C_LO; p <= C_HI; p++) begin : g_c_entry
    assign c_entry[p] = b_state[p-1];
  end

  seqdet_track #(.LO(A_LO), .HI(A_HI)) u_track_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(valid_i), .hit_i(cls.is_a),
    .entry_i(a_entry), .state_o(a_state)
  );

  seqdet_track #(.LO(B_LO), .HI(B_HI)) u_track_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(valid_i), .hit_i(cls.is_b),
    .entry_i(b_entry), .state_o(b_state)
  );

  seqdet_track #(.LO(C_LO), .HI(C_HI)) u_track_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(valid_i), .hit_i(cls.is_c),
    .entry_i(c_entry), .state_o(c_state)
  );

  // Last slot: c after a b or c sitting at WIN_LEN-1.
  assign final_hit = cls.is_c & (b_state[B_HI] | c_state[C_HI]);

  seqdet_report #(.CNT_W(CNT_W)) u_report (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (valid_i),
    .hit_i   (final_hit),
    .report_o(report_o),
    .pos_o   (pos_o)
  );

  p_report_ends_c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o |-> ($past(valid_i) && $past(sym_i) == C_CODE));
endmodule

// File: tb/seqdet_ordered_match_tb_top.sv
module seqdet_ordered_match_tb_top;
  localparam byte CA = 8'h61;
  localparam byte CB = 8'h62;
  localparam byte CC = 8'h63;
  localparam byte CD = 8'h64;
  localparam int  WIN = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  sym_i = 8'h00;
  logic        report_o;
  logic [31:0] pos_o;

  always #5 clk_i = ~clk_i;

  seqdet_ordered_match dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sym_i(sym_i),
    .report_o(report_o), .pos_o(pos_o)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  byte         win_q[$];
  int unsigned acc = 0;
  bit          exp_rep = 1'b0;
  int unsigned exp_pos = 0;
  string       tag = "R7";
  bit          done = 1'b0;

  function automatic bit window_ok();
    if (win_q.size() != WIN) return 1'b0;
    if (win_q[0] != CA || win_q[WIN-1] != CC) return 1'b0;
    for (int i = 1; i < WIN; i++) begin
      byte pr = win_q[i-1];
      byte cu = win_q[i];
      if (pr == CA && !(cu == CA || cu == CB)) return 1'b0;
      if (pr == CB && !(cu == CB || cu == CC)) return 1'b0;
      if (pr == CC && cu != CC) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check();
    n_chk++;
    if (report_o !== exp_rep) begin
      n_bad++;
      $display("FAIL %s report_o actual=%0b expected=%0b t=%0t", tag, report_o, exp_rep, $time);
    end
    n_chk++;
    if (pos_o !== exp_pos) begin
      n_bad++;
      $display("FAIL %s (R8 pos) pos_o actual=%0d expected=%0d t=%0t", tag, pos_o, exp_pos, $time);
    end
  endtask

  task automatic step(bit v, byte s, string t);
    @(negedge clk_i);
    check();
    valid_i = v;
    sym_i   = s;
    tag     = v ? t : "R6";
    exp_rep = 1'b0;
    if (v) begin
      win_q.push_back(s);
      if (win_q.size() > WIN) void'(win_q.pop_front());
      acc++;
      if (window_ok()) begin
        exp_rep = 1'b1;
        exp_pos = acc;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    check();
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    win_q.delete();
    acc     = 0;
    exp_rep = 1'b0;
    exp_pos = 0;
    tag     = "R7";
    repeat (2) begin
      @(negedge clk_i);
      check();
    end
    rst_ni = 1'b1;
  endtask

  task automatic send(string s, string t);
    for (int i = 0; i < s.len(); i++) step(1'b1, s[i], t);
    step(1'b0, CD, t);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset();                           // R7 reset state
    send("aaaaaaac", "R5");               // no report
    send("abcccccc", "R2");               // report, pos 16
    send("aaaaaabc", "R3");               // sixth-slot a boundary
    send("abbbbbbc", "R1");
    send("aabbccccc", "R4");              // two adjacent overlapping windows
    send("abcxabcccccc", "R9");           // x kills first candidate
    // R6: idle cycles inside a window do not disturb it
    step(1'b1, CA, "R6"); step(1'b0, CC, "R6"); step(1'b1, CB, "R6");
    step(1'b0, CD, "R6"); step(1'b0, CA, "R6");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, CC, "R6");
      step(1'b0, CB, "R6");
    end
    // R7: reset mid-window, then first symbol opens a fresh window
    send("abccc", "R7");
    do_reset();
    send("ccc", "R7");
    send("abcccccc", "R7");               // pos 11 after reset (R8)
    // Random runs with idles and stray letters
    begin
      int letter = 0;
      int run = 1;
      for (int n = 0; n < 4000; n++) begin
        bit  v = ($urandom % 6) != 0;
        byte s;
        if (run == 0) begin
          int r = $urandom % 10;
          letter = (r == 0) ? 3 : (r < 3) ? 0 : (letter + 1) % 3;
          run = 1 + ($urandom % 4);
        end
        case (letter)
          0: s = CA;
          1: s = CB;
          2: s = CC;
          default: s = CD;
        endcase
        if (v) run--;
        step(v, s, "R1");
      end
    end
    step(1'b0, CD, "R6");
    @(negedge clk_i);
    check();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule